// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs one read or one write at a time on an external 8-bit bus on which the low address byte and the data share the same pins. The high address byte goes out on its own port. An internal requester presents an address, write data, a direction, a data-memory select and an extended-timing option. The controller then steps through a fixed sequence of phases. It returns read data and a one-clock completion pulse.

The phases run in this order. A setup clock puts the address and control lines on the bus. The active-low address strobe then pulses for one clock. A gap clock follows, in which the address leaves the shared pins. The active-low data strobe is then held low, longer for a read than for a write. The sequence ends with a hold clock. During it, direction, memory select and write data stay valid after the data strobe has risen. Read data is captured at the rising edge of the data strobe. Extended timing stretches the data strobe by two clocks.

Top module: `xbus_ctrl`

## Requirements
- R1: During and after reset, as_n and ds_n are 1, rw_n is 1 (read), dm_n is 1, ad_oe is 0, and busy and done are 0.
- R2: In the first clock after a request is accepted, the address low byte is driven on ad_out with ad_oe=1, and hi_addr carries the address high byte. In that clock as_n is 1 and rw_n and dm_n are already valid. In the second clock as_n is 0, for exactly one clock.
- R3: In the clock after as_n rises, both strobes are high. For a read, ad_oe is 0 there and for the whole time ds_n is low. For a write, ad_out already carries the write data.
- R4: Without extended timing, ds_n stays low for 3 clocks on a read and 2 clocks on a write.
- R5: With extended timing (req_ext=1), the ds_n low time grows by exactly 2 clocks, to 5 for a read and 4 for a write.
- R6: On a write, the write data is driven with ad_oe=1 from the gap clock through the clock after ds_n rises.
- R7: On a read, rdata takes the value on ad_in in the last clock that ds_n is low. It is valid from the clock after ds_n rises, and it holds until the next read completes.
- R8: rw_n (0 = write, 1 = read) and dm_n (0 = data memory selected) stay constant from the setup clock through the clock after ds_n rises.
- R9: done is 1 for exactly one clock, the clock right after ds_n rises. busy is 1 from the setup clock through that clock.
- R10: A req_valid that arrives while busy is 1 is ignored. The bus values in progress do not change, and no new cycle starts after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a bus cycle (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dmem | input | 1 | 1 = data-memory space |
| req_ext | input | 1 | 1 = extended timing |
| req_addr | input | 16 | Address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read data |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | 1 = read, 0 = write |
| dm_n | output | 1 | Data-memory select, active low |
| hi_addr | output | 8 | Address high byte |
| ad_out | output | 8 | Shared pins, outgoing value |
| ad_in | input | 8 | Shared pins, incoming value |
| ad_oe | output | 1 | Drive enable for the shared pins |

## Verification
The bench runs all eight combinations of direction, memory select and extended timing, each with several address and data patterns. It predicts every output in every clock of each cycle from the phase arithmetic. This separates read from write strobe lengths and normal from extended timing. It also catches any mix-up between address and data on the shared pins. On reads, ad_in is valid only in the last low clock of the data strobe and is corrupted right after. A capture one clock early or late therefore shows up in rdata. One pattern per combination keeps req_valid asserted with a different address for the whole cycle, to show that requests made while busy are ignored.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ASL,
        PH_GAP,
        PH_DSL,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic wr;
        logic dmem;
        logic ext;
    } req_ctl_t;

    // Number of clocks the data strobe stays low.
    function automatic int unsigned ds_clocks(input logic wr, input logic ext,
                                              input int unsigned rd_n,
                                              input int unsigned wr_n,
                                              input int unsigned ext_n);
        int unsigned n;
        n = wr ? wr_n : rd_n;
        if (ext) n = n + ext_n;
        return n;
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int unsigned RD_DS  = 3,
    parameter int unsigned WR_DS  = 2,
    parameter int unsigned EXT_DS = 2,
    localparam int unsigned CNT_W = $clog2(RD_DS + EXT_DS + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   wr_q,
    input  logic   ext_q,
    output phase_e phase,
    output logic   capture
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;
    logic             last;

    assign len     = CNT_W'(ds_clocks(wr_q, ext_q, RD_DS, WR_DS, EXT_DS));
    assign last    = (cnt == len - CNT_W'(1));
    assign capture = (phase == PH_DSL) && last && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE:  if (start) phase <= PH_SETUP;
                PH_SETUP: phase <= PH_ASL;
                PH_ASL:   phase <= PH_GAP;
                PH_GAP: begin
                    phase <= PH_DSL;
                    cnt   <= '0;
                end
                PH_DSL: begin
                    if (last) phase <= PH_HOLD;
                    else      cnt   <= cnt + CNT_W'(1);
                end
                PH_HOLD:  phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R9
    hold_follows_ds_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DSL && last) |=> (phase == PH_HOLD));

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              capture,
    input  phase_e            phase,
    input  req_ctl_t          ctl_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] ad_in,
    output req_ctl_t          ctl_q,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   hi_addr,
    output logic              rw_n,
    output logic              dm_n
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              addr_ph;
    logic              active;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (start) begin
                ctl_q   <= ctl_in;
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            if (capture) rdata <= ad_in;
        end
    end

    always_comb begin
        addr_ph = (phase == PH_SETUP) || (phase == PH_ASL);
        active  = (phase != PH_IDLE);
        ad_oe   = addr_ph || (ctl_q.wr && active);
        ad_out  = addr_ph ? addr_q[DATA_W-1:0] : wdata_q;
        hi_addr = addr_q[ADDR_W-1:DATA_W];
        rw_n    = !(ctl_q.wr && active);
        dm_n    = !(ctl_q.dmem && active);
    end

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(capture) |-> $stable(rdata));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RD_DS  = 3,
    parameter int unsigned WR_DS  = 2,
    parameter int unsigned EXT_DS = 2,
    localparam int unsigned HI_W  = ADDR_W - DATA_W,
    localparam int unsigned CNT_W = $clog2(RD_DS + EXT_DS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_dmem,
    input  logic              req_ext,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw_n,
    output logic              dm_n,
    output logic [HI_W-1:0]   hi_addr,
    output logic [DATA_W-1:0] ad_out,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ad_oe
);

    phase_e   phase;
    logic     start;
    logic     capture;
    req_ctl_t ctl_in;
    req_ctl_t ctl_q;

    assign start  = req_valid && (phase == PH_IDLE);
    assign ctl_in = '{wr: req_write, dmem: req_dmem, ext: req_ext};

    xbus_seq #(
        .RD_DS (RD_DS),
        .WR_DS (WR_DS),
        .EXT_DS(EXT_DS)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .wr_q   (ctl_q.wr),
        .ext_q  (ctl_q.ext),
        .phase  (phase),
        .capture(capture)
    );

    xbus_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .capture (capture),
        .phase   (phase),
        .ctl_in  (ctl_in),
        .addr_in (req_addr),
        .wdata_in(req_wdata),
        .ad_in   (ad_in),
        .ctl_q   (ctl_q),
        .rdata   (rdata),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .hi_addr (hi_addr),
        .rw_n    (rw_n),
        .dm_n    (dm_n)
    );

    assign as_n = (phase != PH_ASL);
    assign ds_n = (phase != PH_DSL);
    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_HOLD);

    // Low-time counter for the data strobe, used only by checks.
    logic [CNT_W-1:0] ds_low_cnt;
    always_ff @(posedge clk) begin
        if (rst)        ds_low_cnt <= '0;
        else if (!ds_n) ds_low_cnt <= ds_low_cnt + CNT_W'(1);
        else            ds_low_cnt <= '0;
    end

    // R2
    as_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !as_n |=> as_n);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!as_n && !ds_n));

    // R3
    read_float_chk: assert property (@(posedge clk) disable iff (rst)
        (!ds_n && rw_n) |-> !ad_oe);

    // R4 R5
    ds_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ds_n) |-> (ds_low_cnt ==
            CNT_W'(ds_clocks(!rw_n, ctl_q.ext, RD_DS, WR_DS, EXT_DS))));

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ds_n) && !rw_n) |-> ad_oe);

    // R8
    ctl_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(rw_n) && $stable(dm_n)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: tb/xbus_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_dmem, req_ext;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        busy, done, as_n, ds_n, rw_n, dm_n, ad_oe;
    logic [7:0]  rdata, hi_addr, ad_out, ad_in;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    xbus_ctrl u_xbus_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_dmem(req_dmem),
        .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dm_n(dm_n),
        .hi_addr(hi_addr), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input bit wr, input bit dm, input bit ext,
                       input logic [15:0] addr, input logic [7:0] wd,
                       input logic [7:0] rd, input bit hammer);
        int unsigned nds;
        int unsigned last;
        nds  = (wr ? 2 : 3) + (ext ? 2 : 0);
        last = 4 + nds;
        req_valid = 1'b1; req_write = wr; req_dmem = dm; req_ext = ext;
        req_addr = addr; req_wdata = wd; ad_in = ~rd;
        for (int k = 1; k <= int'(last); k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (hammer) begin
                    req_addr = ~addr; req_wdata = ~wd; req_write = ~wr;
                end else begin
                    req_valid = 1'b0;
                end
            end
            chk("R9", "busy", busy, 1);
            chk("R9", "done", done, (k == int'(last)) ? 1 : 0);
            chk("R2", "as_n", as_n, (k == 2) ? 0 : 1);
            chk("R4", "ds_n", ds_n, (k >= 4 && k < int'(last)) ? 0 : 1);
            chk("R8", "rw_n", rw_n, wr ? 0 : 1);
            chk("R8", "dm_n", dm_n, dm ? 0 : 1);
            chk("R10", "hi_addr", hi_addr, addr[15:8]);
            if (k <= 2) begin
                chk("R2", "ad_oe", ad_oe, 1);
                chk("R2", "ad_out addr", ad_out, addr[7:0]);
            end else if (wr) begin
                chk("R6", "ad_oe", ad_oe, 1);
                chk("R3", "ad_out wdata", ad_out, wd);
            end else begin
                chk("R3", "ad_oe float", ad_oe, 0);
            end
            if (k == int'(last) - 1) ad_in = rd;
            if (k == int'(last)) begin
                if (ext) chk("R5", "ds low count", nds, wr ? 4 : 5);
                if (!wr) chk("R7", "rdata", rdata, rd);
                ad_in = ~rd;
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R10", "idle after done", {busy, as_n, done}, 3'b010);
        if (!wr) chk("R7", "rdata held", rdata, rd);
        chk("R1", "oe idle", ad_oe, 0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_dmem = 1'b0;
        req_ext = 1'b0; req_addr = '0; req_wdata = '0; ad_in = '0;
        repeat (3) @(negedge clk);
        chk("R1", "as_n", as_n, 1);
        chk("R1", "ds_n", ds_n, 1);
        chk("R1", "rw_n", rw_n, 1);
        chk("R1", "dm_n", dm_n, 1);
        chk("R1", "ad_oe", ad_oe, 0);
        chk("R1", "busy/done", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic [15:0] a;
                logic [7:0]  w, r;
                a = 16'(p * 16'h3b21 + c * 16'h0457 + 16'h1200);
                w = 8'(p * 8'h5d + c * 8'h13 + 8'h01);
                r = 8'(p * 8'h29 + c * 8'h71 + 8'h0c);
                run(c[2], c[1], c[0], a, w, r, p == 2);
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule